// File: doc/BRIEF.md
# BCD Real-Time Clock with Halt-and-Load Holding Registers

This block keeps calendar time (seconds, minutes, hours, day of week, date, month and two-digit year) in BCD counters that advance on a one-per-second tick input. The host never reads or writes those counters directly. It sees a separate bank of holding registers placed in the top eight bytes of an 11-bit (2K byte) address space. While the clock runs freely, the holding bank copies the counters on every cycle. A control byte at the lowest of those eight addresses carries two halt bits. One freezes the bank so a consistent snapshot can be read. The other opens the bank for loading, and the counters take the loaded values when that bit is cleared.

The counters keep running while the bank is frozen for reading. Loading replaces the counters only at the moment of commit. Calibration, alarms and century handling are not part of this block. The six low control bits are only a stored byte.

The host port is a plain single-cycle bus. Every write request is taken in the cycle it is presented. A read request returns its data one cycle later with a `rd_valid` strobe. There is no back-pressure in either direction: the host must accept `rd_data` in the cycle `rd_valid` is high.

Top module: `rtc_shadow`

## Requirements
- R1: After reset the control byte reads 00h and the time reads 00:00:00, day 1, date 01, month 01, year 00.
- R2: Register map: 7F8h control, 7F9h seconds, 7FAh minutes, 7FBh hours, 7FCh day of week, 7FDh date, 7FEh month, 7FFh year. A read presented in one cycle returns its byte in the next cycle with rd_valid high. Addresses below 7F8h read 00h and ignore writes.
- R3: With control bits 7 and 6 both 0, the holding registers take the counter values every cycle, so each tick is visible at the following read.
- R4: Control bit 6 (freeze) set to 1 holds the holding registers at the time current when it was written. The counters keep counting, and after the bit returns to 0 the reads show the advanced time.
- R5: Control bit 7 (load) set to 1 also stops holding register updates. Writes to 7F9h–7FFh are stored only while bit 7 is 1 and are ignored otherwise.
- R6: A control write that changes bit 7 from 1 to 0 copies all seven holding registers into the counters in that cycle. If a tick arrives in the same cycle, the loaded value wins.
- R7: Bits with no meaning store and read as 0: seconds bit 7, minutes bit 7, hours bits 7:6, day bits 7:3, date bits 7:6, month bits 7:5.
- R8: Control bits 5:0 are stored and read back unchanged and have no effect on counting.
- R9: Seconds and minutes roll 59→00 with carry, and hours roll 23→00 (24-hour BCD) with carry into day and date.
- R10: Day of week rolls 7→1. Date rolls to 01 after the month's last day (30 for months 04, 06, 09, 11; 28 for February, or 29 when the BCD year is a multiple of 4; else 31). Month rolls 12→01, and year rolls 99→00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Write request this cycle |
| bus_re | input | 1 | Read request this cycle |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after bus_re |
| rd_data | output | 8 | Read data |

## Verification
Each result has a fixed latency:
- A tick changes the counters at the edge that samples it, and the holding bank follows one edge later.
- A commit loads the counters at the edge of the control write.
- Read data appears one edge after the request.

The bench drives every input at the falling edge and always issues a read at least one full cycle after the last stimulus. It samples rd_data at the next falling edge, where both the tick latency and the read latency have elapsed. Date rollover is swept over every day of a four-year leap cycle. Expected dates are computed arithmetically from month lengths.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef logic [NFIELD-1:0][7:0] rtc_regs_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // ones + 2*tens, modulo 4
  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [1:0] r;
    r = yr[1:0] + {yr[4], 1'b0};
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h7F;
      F_HOUR:       return 8'h3F;
      F_DAY:        return 8'h07;
      F_DATE:       return 8'h3F;
      F_MON:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_reset(input int i);
    return (i == F_DAY || i == F_DATE || i == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_regs_t load_val,
  output rtc_regs_t cnt
);
  rtc_regs_t nxt;

  always_comb begin
    nxt = cnt;
    if (cnt[F_SEC] >= 8'h59) begin
      nxt[F_SEC] = 8'h00;
      if (cnt[F_MIN] >= 8'h59) begin
        nxt[F_MIN] = 8'h00;
        if (cnt[F_HOUR] >= 8'h23) begin
          nxt[F_HOUR] = 8'h00;
          nxt[F_DAY]  = (cnt[F_DAY] >= 8'h07) ? 8'h01 : cnt[F_DAY] + 8'd1;
          if (cnt[F_DATE] >= last_date(cnt[F_MON], cnt[F_YEAR])) begin
            nxt[F_DATE] = 8'h01;
            if (cnt[F_MON] >= 8'h12) begin
              nxt[F_MON]  = 8'h01;
              nxt[F_YEAR] = (cnt[F_YEAR] >= 8'h99) ? 8'h00 : bcd_inc(cnt[F_YEAR]);
            end else begin
              nxt[F_MON] = bcd_inc(cnt[F_MON]);
            end
          end else begin
            nxt[F_DATE] = bcd_inc(cnt[F_DATE]);
          end
        end else begin
          nxt[F_HOUR] = bcd_inc(cnt[F_HOUR]);
        end
      end else begin
        nxt[F_MIN] = bcd_inc(cnt[F_MIN]);
      end
    end else begin
      nxt[F_SEC] = bcd_inc(cnt[F_SEC]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) cnt[i] <= field_reset(i);
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= nxt;
    end
  end

  // R6: commit copies the holding values, even against a tick
  a_r6_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R9: seconds wrap
  a_r9_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt[F_SEC] == 8'h59) |=> cnt[F_SEC] == 8'h00);
  // R9: hours wrap at midnight
  a_r9_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt[F_SEC] == 8'h59 && cnt[F_MIN] == 8'h59 && cnt[F_HOUR] == 8'h23)
      |=> cnt[F_HOUR] == 8'h00);
endmodule

// File: rtl/rtc_hold.sv
module rtc_hold
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rtc_regs_t         cnt,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output rtc_regs_t         hold,
  output logic              load,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  localparam int HI_W = ADDR_W - 3;

  logic [7:0] ctrl;
  logic       in_win, is_ctrl, frozen, loading;
  logic [2:0] off;

  assign off     = addr[2:0];
  assign in_win  = (addr[ADDR_W-1:3] == {HI_W{1'b1}});
  assign is_ctrl = in_win && (off == 3'd0);
  assign frozen  = ctrl[6];
  assign loading = ctrl[7];
  assign load    = we && is_ctrl && loading && !wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= 8'h00;
      for (int i = 0; i < NFIELD; i++) hold[i] <= field_reset(i);
    end else begin
      if (we && is_ctrl) ctrl <= wdata;
      for (int i = 0; i < NFIELD; i++) begin
        if (we && in_win && off == 3'(i + 1) && loading)
          hold[i] <= wdata & field_mask(i);
        else if (!loading && !frozen)
          hold[i] <= cnt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= re;
      if (re) begin
        if (!in_win)      rd_data <= 8'h00;
        else if (is_ctrl) rd_data <= ctrl;
        else              rd_data <= hold[off - 3'd1];
      end
    end
  end

  // R3: free-running bank follows the counters one cycle behind
  a_r3_tracks_counters: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !frozen) |=> hold == $past(cnt));
  // R4: frozen bank does not move
  a_r4_freeze_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !loading) |=> $stable(hold));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  rtc_regs_t cnt, hold;
  logic      load;

  rtc_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .load     (load),
    .load_val (hold),
    .cnt      (cnt)
  );

  rtc_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .we       (bus_we),
    .re       (bus_re),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .hold     (hold),
    .load     (load),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/rtc_shadow_test.sv
module rtc_shadow_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam int A_CTRL = 'h7F8, A_SEC = 'h7F9, A_MIN = 'h7FA, A_HOUR = 'h7FB;
  localparam int A_DAY = 'h7FC, A_DATE = 'h7FD, A_MON = 'h7FE, A_YEAR = 'h7FF;

  always #2 clk = ~clk;

  rtc_shadow uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 11'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = 11'(a);
    @(negedge clk);
    bus_re = 1'b0;
    if (!rd_valid) begin
      total++; bad++;
      $display("FAIL R2 rd_valid actual=0 expected=1");
    end
    d = int'(rd_data);
  endtask

  task automatic rdchk(input string req, input int a, input int exp);
    int v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int dw,
                          input int dt, input int mo, input int y);
    wr(A_CTRL, 'h80);
    wr(A_SEC, bcd(s)); wr(A_MIN, bcd(mi)); wr(A_HOUR, bcd(h)); wr(A_DAY, dw);
    wr(A_DATE, bcd(dt)); wr(A_MON, bcd(mo)); wr(A_YEAR, bcd(y));
    wr(A_CTRL, 'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk("R1 ctrl", A_CTRL, 'h00);
    rdchk("R1 sec", A_SEC, 'h00);
    rdchk("R1 hour", A_HOUR, 'h00);
    rdchk("R1 day", A_DAY, 'h01);
    rdchk("R1 date", A_DATE, 'h01);
    rdchk("R1 month", A_MON, 'h01);
    rdchk("R1 year", A_YEAR, 'h00);

    // R2 out-of-window address
    wr('h100, 'h5A);
    rdchk("R2 unmapped read", 'h100, 'h00);

    // R3/R9 seconds sweep with tracking
    set_time(0, 0, 0, 1, 1, 1, 0);
    for (int k = 1; k <= 60; k++) begin
      tick();
      rdchk("R3 R9 seconds", A_SEC, bcd(k % 60));
    end
    rdchk("R9 minute carry", A_MIN, 'h01);

    // R9 minute/hour carry
    set_time(59, 59, 0, 1, 1, 1, 0);
    tick();
    rdchk("R9 hour carry", A_HOUR, 'h01);
    rdchk("R9 min wrap", A_MIN, 'h00);

    // R10 sweep every day of a four-year cycle
    dw = 1;
    for (int y = 0; y < 4; y++)
      for (int m = 1; m <= 12; m++)
        for (int d = 1; d <= mlen(m, y); d++) begin
          int nd, nm, ny;
          nd = d + 1; nm = m; ny = y;
          if (d == mlen(m, y)) begin
            nd = 1; nm = (m == 12) ? 1 : m + 1;
            if (m == 12) ny = y + 1;
          end
          set_time(59, 59, 23, dw, d, m, y);
          tick();
          rdchk("R9 midnight hour", A_HOUR, 'h00);
          rdchk("R10 day", A_DAY, (dw % 7) + 1);
          rdchk("R10 date", A_DATE, bcd(nd));
          rdchk("R10 month", A_MON, bcd(nm));
          rdchk("R10 year", A_YEAR, bcd(ny));
          dw = (dw % 7) + 1;
        end

    // R10 year 99 -> 00
    set_time(59, 59, 23, 3, 31, 12, 99);
    tick();
    rdchk("R10 year wrap", A_YEAR, 'h00);

    // R4 freeze
    set_time(30, 20, 10, 2, 15, 6, 5);
    wr(A_CTRL, 'h40);
    tick(); tick(); tick();
    rdchk("R4 frozen sec", A_SEC, 'h30);
    rdchk("R4 frozen ctrl", A_CTRL, 'h40);
    wr(A_CTRL, 'h00);
    rdchk("R4 counters ran", A_SEC, 'h33);

    // R5 writes ignored while load bit clear
    wr(A_SEC, 'h45);
    rdchk("R5 ignored write", A_SEC, 'h33);

    // R5/R7 load window
    wr(A_CTRL, 'h80);
    wr(A_SEC, 'h50);
    tick(); tick();
    rdchk("R5 held written sec", A_SEC, 'h50);
    wr(A_HOUR, 'hE3);
    rdchk("R7 hour mask", A_HOUR, 'h23);
    wr(A_DAY, 'hFD);
    rdchk("R7 day mask", A_DAY, 'h05);
    wr(A_SEC, 'hD9);
    rdchk("R7 sec mask", A_SEC, 'h59);
    wr(A_CTRL, 'h00);
    rdchk("R6 commit sec", A_SEC, 'h59);
    rdchk("R6 commit hour", A_HOUR, 'h23);
    tick();
    rdchk("R6 R9 after commit", A_SEC, 'h00);

    // R6 commit beats simultaneous tick
    wr(A_CTRL, 'h80);
    wr(A_SEC, 'h10);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 11'(A_CTRL); bus_wdata = 8'h00; sec_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; sec_tick = 1'b0;
    rdchk("R6 load wins over tick", A_SEC, 'h10);

    // R8 calibration bits stored, no effect
    wr(A_CTRL, 'h15);
    rdchk("R8 ctrl readback", A_CTRL, 'h15);
    tick();
    rdchk("R8 counting unaffected", A_SEC, 'h11);
    wr(A_CTRL, 'h00);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule